// File: doc/BRIEF.md
# Programmable Clock Divider Bank

Six independent frequency generators share two 32-bit control registers, three generators to a register. Each generator picks one of three source tick enables (a core-clock tick, an auxiliary-PLL tick and a second auxiliary-PLL tick), divides it by a programmed ratio, and drives two outputs in the fast clock domain: a divided clock level and a one-cycle tick that marks the start of each output period. Software writes and reads the control words through a plain register port. A `resume_i` pulse per generator re-enables a generator from the last source it used.

The `EXT_LAYOUT` parameter picks one of two field layouts. The legacy layout (`EXT_LAYOUT=0`) has a one-bit source select, a separate enable bit and even ratios only. The extended layout (`EXT_LAYOUT=1`) has a two-bit source mux in which code zero means off. It also has a per-register scale bit that allows odd ratios. A new setting never cuts a period short: the active setting is only replaced at an output period boundary, so the divided clock has no runt pulses.

Top module: `fgen_bank`

## Requirements
- R1: After reset, both control registers read zero, every generator is off, and all `gen_clk_o` and `gen_tick_o` bits are low.
- R2: Generator g lives in register g/3 at bit offset 10*(g mod 3). Its 8-bit divider value N sits at field bits [9:2], and a write to one register leaves the generators of the other register unchanged.
- R3: Legacy layout: field bit 0 picks the source (0 = `src_tick_i[0]`, 1 = `src_tick_i[1]`), field bit 1 enables the generator, and the ratio is (N+1)*2 source ticks.
- R4: Extended layout: field bits [1:0] are the source mux. Code 0 is off, code 1 picks `src_tick_i[2]`, code 2 picks `src_tick_i[0]` and code 3 picks `src_tick_i[1]`.
- R5: Extended layout: register bit 30 applies to the three generators of its own register. When it is clear the ratio is (N+1)*2; when it is set the ratio is N+1. The legacy layout has no scale bit.
- R6: For a ratio R, `gen_clk_o` is high for ceil(R/2) source ticks and low for the rest of the period. `gen_tick_o` pulses for one cycle at the start of each period, together with the rising level.
- R7: A new divider or source setting written while a generator runs takes effect only after the current period completes.
- R8: A generator that is off holds `gen_clk_o` and `gen_tick_o` low.
- R9: Reads return the stored bits as written. Bit 31 always reads zero, and bit 30 also reads zero in the legacy layout.
- R10: Extended layout: a `resume_i[g]` pulse while generator g's mux reads 0 writes back the last nonzero mux code written for it, or code 1 if none has been written since reset. In the legacy layout `resume_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register index for writes |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 1 | Register index for reads |
| rd_data_o | output | 32 | Read data (combinational) |
| resume_i | input | 6 | Per-generator re-enable pulse |
| src_tick_i | input | 3 | Source tick enables: [0] core, [1] aux PLL, [2] second aux PLL |
| gen_clk_o | output | 6 | Divided clock levels |
| gen_tick_o | output | 6 | Period-start ticks |

## Verification
The bench measures steady-state period and high time on each source and mux code, and it covers odd ratios and ratio 1 with the scale bit set. A decoder that mapped the mux codes in the wrong order, or applied the scale bit across registers, would produce a wrong period. It rewrites a running divider in mid-period and checks that the old period still ends on its original cycle; a design that reconfigured at once would tick early. It also checks that an off generator stays low, and that resume restores the earlier source in the extended layout but leaves the legacy register untouched. A design that lost the shadow code or ignored the layout would fail one of those readbacks.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
  localparam int FIELD_W     = 10;
  localparam int GEN_PER_REG = 3;
  localparam int DIV_W       = 8;
  localparam int RATIO_W     = DIV_W + 2;
  localparam int NUM_SRC     = 3;
  localparam int SCALE_BIT   = 30;
  localparam int REG_W       = 32;

  localparam logic [1:0] SRC_CORE = 2'd0;
  localparam logic [1:0] SRC_AUX  = 2'd1;
  localparam logic [1:0] SRC_AUX2 = 2'd2;

  typedef struct packed {
    logic               en;
    logic [1:0]         src;
    logic [RATIO_W-1:0] ratio;
  } gen_cfg_t;

  function automatic gen_cfg_t decode_field(input logic [FIELD_W-1:0] f,
                                            input logic scale,
                                            input logic ext);
    gen_cfg_t c;
    logic [RATIO_W-1:0] n1;
    n1 = {2'b00, f[FIELD_W-1:2]} + {{(RATIO_W-1){1'b0}}, 1'b1};
    if (ext) begin
      c.en = (f[1:0] != 2'd0);
      case (f[1:0])
        2'd1:    c.src = SRC_AUX2;
        2'd2:    c.src = SRC_CORE;
        default: c.src = SRC_AUX;
      endcase
      c.ratio = scale ? n1 : (n1 << 1);
    end else begin
      c.en    = f[1];
      c.src   = f[0] ? SRC_AUX : SRC_CORE;
      c.ratio = n1 << 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/fgen_regs.sv
module fgen_regs
  import fgen_pkg::*;
#(
  parameter bit EXT_LAYOUT = 1'b1,
  parameter int NUM_GEN    = 6,
  localparam int NUM_REG   = NUM_GEN / GEN_PER_REG,
  localparam int ADDR_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [REG_W-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [REG_W-1:0]     rd_data_o,
  input  logic [NUM_GEN-1:0]   resume_i,
  output gen_cfg_t [NUM_GEN-1:0] cfg_o
);
  localparam int FIELDS_W = GEN_PER_REG * FIELD_W;
  localparam logic [REG_W-1:0] KEEP_MASK =
    EXT_LAYOUT ? ((REG_W'(1) << SCALE_BIT) | ((REG_W'(1) << FIELDS_W) - 1))
               : ((REG_W'(1) << FIELDS_W) - 1);

  logic [REG_W-1:0]   reg_q   [NUM_REG];
  logic [REG_W-1:0]   reg_nxt [NUM_REG];
  logic [NUM_REG-1:0] wr_hit;
  logic [1:0]         shadow_q [NUM_GEN];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_hit
    assign wr_hit[r] = wr_en_i && (wr_addr_i == ADDR_W'(r));
  end

  always_comb begin
    for (int r = 0; r < NUM_REG; r++) begin
      reg_nxt[r] = wr_hit[r] ? (wr_data_i & KEEP_MASK) : reg_q[r];
      if (EXT_LAYOUT) begin
        for (int g = 0; g < GEN_PER_REG; g++) begin
          if (resume_i[r*GEN_PER_REG+g] && reg_nxt[r][g*FIELD_W +: 2] == 2'd0)
            reg_nxt[r][g*FIELD_W +: 2] = shadow_q[r*GEN_PER_REG+g];
        end
      end
    end
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reg_q[r] <= '0;
      else         reg_q[r] <= reg_nxt[r];
    end

    p_unused_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_q[r][REG_W-1] == 1'b0) && (EXT_LAYOUT || reg_q[r][SCALE_BIT] == 1'b0));
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int RI  = g / GEN_PER_REG;
    localparam int OFF = FIELD_W * (g % GEN_PER_REG);

    assign cfg_o[g] = decode_field(reg_q[RI][OFF +: FIELD_W],
                                   reg_q[RI][SCALE_BIT], EXT_LAYOUT);

    if (EXT_LAYOUT) begin : g_shadow
      // last nonzero mux code, used by resume
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            shadow_q[g] <= 2'd1;
        else if (reg_nxt[RI][OFF +: 2] != 2'd0) shadow_q[g] <= reg_nxt[RI][OFF +: 2];
      end

      p_shadow_nonzero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shadow_q[g] != 2'd0);
      p_resume_restores_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resume_i[g] && !wr_hit[RI] && reg_q[RI][OFF +: 2] == 2'd0)
        |=> reg_q[RI][OFF +: 2] == $past(shadow_q[g]));
    end else begin : g_noshadow
      assign shadow_q[g] = 2'd1;
      p_legacy_resume_inert_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resume_i[g] && !wr_hit[RI]) |=> $stable(reg_q[RI][OFF +: FIELD_W]));
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int r = 0; r < NUM_REG; r++)
      if (rd_addr_i == ADDR_W'(r)) rd_data_o = reg_q[r];
  end
endmodule

// File: rtl/fgen_divider.sv
module fgen_divider
  import fgen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  gen_cfg_t           cfg_i,
  input  logic [NUM_SRC-1:0] src_tick_i,
  output logic               clk_o,
  output logic               tick_o
);
  logic               act_en;
  logic [1:0]         act_src;
  logic [RATIO_W-1:0] act_ratio;
  logic [RATIO_W-1:0] cnt_q;
  logic               clk_q, tick_q;
  logic [3:0]         src_ext;
  logic               src_t, at_end, boundary;
  logic [RATIO_W-1:0] half, cnt_inc;

  assign src_ext  = {{(4-NUM_SRC){1'b0}}, src_tick_i};
  assign src_t    = src_ext[act_src];
  assign at_end   = src_t && (cnt_q == act_ratio - 1'b1);
  assign boundary = !act_en || at_end;
  assign half     = (act_ratio + 1'b1) >> 1;
  assign cnt_inc  = cnt_q + 1'b1;

  // active setting swaps only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en    <= 1'b0;
      act_src   <= SRC_CORE;
      act_ratio <= '0;
      cnt_q     <= '0;
      clk_q     <= 1'b0;
      tick_q    <= 1'b0;
    end else if (boundary) begin
      act_en    <= cfg_i.en;
      act_src   <= cfg_i.src;
      act_ratio <= cfg_i.ratio;
      cnt_q     <= '0;
      clk_q     <= cfg_i.en;
      tick_q    <= cfg_i.en;
    end else if (src_t) begin
      cnt_q  <= cnt_inc;
      clk_q  <= (cnt_inc < half);
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign clk_o  = clk_q;
  assign tick_o = tick_q;

  p_tick_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> clk_q);
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_en |-> (cnt_q < act_ratio));
  p_hold_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_en && !at_end) |=> ($stable(act_ratio) && $stable(act_src)));
  p_off_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_en |-> (!clk_q && !tick_q));
endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
  import fgen_pkg::*;
#(
  parameter bit EXT_LAYOUT = 1'b1,
  parameter int NUM_GEN    = 6,
  localparam int NUM_REG   = NUM_GEN / GEN_PER_REG,
  localparam int ADDR_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic [NUM_GEN-1:0] resume_i,
  input  logic [NUM_SRC-1:0] src_tick_i,
  output logic [NUM_GEN-1:0] gen_clk_o,
  output logic [NUM_GEN-1:0] gen_tick_o
);
  gen_cfg_t [NUM_GEN-1:0] cfg;

  fgen_regs #(.EXT_LAYOUT(EXT_LAYOUT), .NUM_GEN(NUM_GEN)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .resume_i (resume_i),
    .cfg_o    (cfg)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_div
    fgen_divider u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_i     (cfg[g]),
      .src_tick_i(src_tick_i),
      .clk_o     (gen_clk_o[g]),
      .tick_o    (gen_tick_o[g])
    );
  end
endmodule

// File: tb/fgen_bank_bench.sv
`timescale 1ns/1ps
module fgen_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_e = 1'b0, wr_en_l = 1'b0;
  logic        wr_addr = 1'b0, rd_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_e, rd_l;
  logic [5:0]  res_e = '0, res_l = '0;
  logic [2:0]  src = '0;
  logic [5:0]  gclk_e, tick_e, gclk_l, tick_l;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  fgen_bank #(.EXT_LAYOUT(1'b1)) u_fgen_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_e), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_e),
    .resume_i(res_e), .src_tick_i(src), .gen_clk_o(gclk_e), .gen_tick_o(tick_e));

  fgen_bank #(.EXT_LAYOUT(1'b0)) u_fgen_bank_legacy (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_l), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_l),
    .resume_i(res_l), .src_tick_i(src), .gen_clk_o(gclk_l), .gen_tick_o(tick_l));

  // core tick every cycle, aux every 2nd, aux2 every 3rd
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      src[0] = 1'b1;
      src[1] = (cyc % 2 == 0);
      src[2] = (cyc % 3 == 0);
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic tk(input bit ext, input int g);
    return ext ? tick_e[g] : tick_l[g];
  endfunction
  function automatic logic lv(input bit ext, input int g);
    return ext ? gclk_e[g] : gclk_l[g];
  endfunction

  // scoreboard
  typedef struct {
    bit    ext;
    int    gen;
    int    period;
    int    high;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  bit   busy = 1'b0;

  initial begin
    exp_t cur;
    int per, hi, w;
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        cur  = exp_q.pop_front();
        busy = 1'b1;
        w = 0;
        while (!tk(cur.ext, cur.gen) && w < 5000) begin @(negedge clk); w++; end
        @(negedge clk);
        while (!tk(cur.ext, cur.gen) && w < 10000) begin @(negedge clk); w++; end
        per = 0; hi = 0;
        do begin
          if (lv(cur.ext, cur.gen)) hi++;
          per++;
          @(negedge clk);
        end while (!tk(cur.ext, cur.gen) && per < 5000);
        check(per == cur.period, {cur.tag, " period"}, per, cur.period);
        check(hi == cur.high, {cur.tag, " high"}, hi, cur.high);
        busy = 1'b0;
      end
    end
  end

  task automatic expect_period(input bit ext, input int g, input int p, input int h, input string tag);
    exp_t it;
    it.ext = ext; it.gen = g; it.period = p; it.high = h; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  task automatic wr(input bit ext, input bit a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d;
    if (ext) wr_en_e = 1'b1; else wr_en_l = 1'b1;
    @(negedge clk);
    wr_en_e = 1'b0; wr_en_l = 1'b0;
  endtask

  task automatic rd_check(input bit ext, input bit a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    if (ext) check(rd_e == exp, tag, rd_e, exp);
    else     check(rd_l == exp, tag, rd_l, exp);
  endtask

  task automatic pulse_resume(input bit ext, input logic [5:0] m);
    @(negedge clk);
    if (ext) res_e = m; else res_l = m;
    @(negedge clk);
    res_e = '0; res_l = '0;
  endtask

  task automatic hold_low(input bit ext, input int g, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (lv(ext, g) || tk(ext, g)) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    int k;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(gclk_e == 0 && tick_e == 0, "R1 ext outputs low", gclk_e, 0);
    check(gclk_l == 0 && tick_l == 0, "R1 legacy outputs low", gclk_l, 0);
    rd_check(1, 0, 32'h0, "R1 ext reg0 zero");
    rd_check(0, 1, 32'h0, "R1 legacy reg1 zero");

    // R9 unused bits read zero
    wr(1, 1, 32'hFFFF_FFFF);
    rd_check(1, 1, 32'h7FFF_FFFF, "R9 ext mask");
    wr(0, 1, 32'hFFFF_FFFF);
    rd_check(0, 1, 32'h3FFF_FFFF, "R9 legacy mask");
    wr(1, 1, 32'h0);
    wr(0, 1, 32'h0);

    // R10 resume after reset picks code 1
    pulse_resume(1, 6'b000001);
    rd_check(1, 0, 32'h0000_0001, "R10 resume default code");

    // R2 R4 R5 R6 ext reg0, scale clear
    wr(1, 0, 32'h0000_4806);
    rd_check(1, 0, 32'h0000_4806, "R9 ext reg0 readback");
    expect_period(1, 0, 4, 2, "R5 ext g0 core N1 scale0");
    expect_period(1, 1, 10, 5, "R2 ext g1 core N4 scale0");
    hold_low(1, 2, 50, "R8 ext g2 code0 off");

    // R4 R5 ext reg1, scale set
    wr(1, 1, 32'h4030_1412);
    rd_check(1, 1, 32'h4030_1412, "R9 ext reg1 readback");
    expect_period(1, 3, 5, 3, "R5 ext g3 odd ratio 5");
    expect_period(1, 4, 6, 3, "R4 ext g4 aux2 ratio 2");
    expect_period(1, 5, 2, 2, "R4 ext g5 aux ratio 1");
    expect_period(1, 0, 4, 2, "R5 scale of reg1 leaves g0");

    // R7 mid-period rewrite of g1: old period of 10 completes
    @(negedge clk);
    while (!tick_e[1]) @(negedge clk);
    k = 0;
    @(negedge clk); k++;
    wr_addr = 1'b0; wr_data = 32'h0000_0806; wr_en_e = 1'b1;
    @(negedge clk); k++;
    wr_en_e = 1'b0;
    while (!tick_e[1] && k < 100) begin @(negedge clk); k++; end
    check(k == 10, "R7 old period completes", k, 10);
    expect_period(1, 1, 2, 1, "R7 new ratio after boundary");

    // R8 disable g1, R10 resume restores code 2
    wr(1, 0, 32'h0000_0006);
    repeat (10) @(negedge clk);
    hold_low(1, 1, 40, "R8 ext g1 disabled low");
    rd_check(1, 0, 32'h0000_0006, "R9 ext g1 mux reads 0");
    pulse_resume(1, 6'b000010);
    rd_check(1, 0, 32'h0000_0806, "R10 resume restores code 2");
    expect_period(1, 1, 2, 1, "R10 resumed g1 runs");

    // R3 legacy layout
    wr(0, 0, 32'h0010_2C02);
    expect_period(0, 0, 2, 1, "R3 legacy g0 core ratio 2");
    expect_period(0, 1, 12, 6, "R3 legacy g1 aux ratio 6");
    hold_low(0, 2, 50, "R8 legacy g2 enable clear");

    // R5 legacy has no scale bit
    wr(0, 1, 32'h4000_0012);
    rd_check(0, 1, 32'h0000_0012, "R9 legacy bit30 dropped");
    expect_period(0, 3, 10, 5, "R5 legacy ignores scale");

    // R10 legacy resume inert
    pulse_resume(0, 6'b000100);
    rd_check(0, 0, 32'h0010_2C02, "R10 legacy resume no effect");
    hold_low(0, 2, 30, "R10 legacy g2 stays off");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule